// File: doc/BRIEF.md
# Single-Cycle Jump Datapath

This block is a slice of a single-cycle integer core that completes one instruction on every clock edge. It holds the program counter and a 32-entry register file. It builds I-type and J-type immediates. Two operand selectors feed an adder/subtractor ALU, and a three-way selector picks the register write-back value. A small decoder drives all of these selects from the opcode fields.

Both unconditional jumps take their target from the shared ALU. The direct jump adds its immediate to the current PC. The register-indirect jump adds its immediate to a source register and clears bit 0 of the sum. Both jumps write the address of the following instruction (PC plus 4) into the destination register. The block also runs add-immediate, register add and register subtract, so link values and jump targets can be built and used.

Instructions come in combinationally on a fetch port. The fetch address is the PC itself. Debug outputs show the PC and the register write that will commit at the next rising edge.

Top module: `jd_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears every register. The fetch address always equals the PC shown on the debug output.
- R2: Every instruction other than the two jumps loads the PC with PC+4 at the next edge.
- R3: The direct jump (opcode 1101111) loads the PC with PC plus the sign-extended immediate {inst[31], inst[19:12], inst[20], inst[30:21], 0}. It writes PC+4 to rd (bits 11:7).
- R4: The indirect jump (opcode 1100111, funct3 = 000) loads the PC with (x[rs1] + sign-extended inst[31:20]) with bit 0 forced to 0. It writes PC+4 to rd. rs1 is in bits 19:15.
- R5: Add-immediate (opcode 0010011, funct3 = 000) writes x[rs1] + sign-extended inst[31:20] to rd.
- R6: Register add and subtract use opcode 0110011 and funct3 = 000, with rs2 in bits 24:20. Funct7 0000000 writes x[rs1]+x[rs2]. Funct7 0100000 writes x[rs1]-x[rs2].
- R7: Register 0 always reads as zero. An instruction naming it as rd commits no write, and the debug write enable stays low.
- R8: Any other opcode, funct3 or funct7 combination writes no register and only advances the PC by 4.
- R9: The debug write enable, index and data show the write that the register file captures at the next rising edge. They stay constant through the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch byte address |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | Register write commits at next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value written |

## Verification
The properties assume that the fetch port returns a fully known instruction word within the same cycle as the address. They also assume the word is a function of that address alone, so each next-PC property can relate the word seen in one cycle to the PC in the following cycle. The bench meets this by serving every fetch from a fixed 64-word array indexed by address bits 7:2. Any address, including an odd one or one past the array after a jump, folds back into valid array contents. The program runs an add-immediate sweep over every destination register, then loops through both jump kinds with odd, positive and negative offsets, writes to register 0, and unsupported encodings.

// File: rtl/jd_pkg.sv
package jd_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic { OPA_RS1, OPA_PC }  opa_sel_e;
    typedef enum logic { OPB_RS2, OPB_IMM } opb_sel_e;
    typedef enum logic { IMMF_I, IMMF_J }   imm_fmt_e;
    typedef enum logic { ALU_ADD, ALU_SUB } alu_fn_e;
    typedef enum logic [1:0] { WBK_ALU, WBK_MEM, WBK_LINK } wbk_sel_e;

    typedef struct packed {
        logic     rf_we;
        opa_sel_e opa;
        opb_sel_e opb;
        imm_fmt_e imm_fmt;
        alu_fn_e  alu_fn;
        wbk_sel_e wbk;
        logic     redirect;
        logic     clr_lsb;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        rf_we: 1'b0, opa: OPA_RS1, opb: OPB_IMM, imm_fmt: IMMF_I,
        alu_fn: ALU_ADD, wbk: WBK_ALU, redirect: 1'b0, clr_lsb: 1'b0
    };

    // Upper instruction field inst[31:12] into I-type immediate
    function automatic logic [XLEN-1:0] imm_of_i(input logic [19:0] hi);
        return {{20{hi[19]}}, hi[19:8]};
    endfunction

    // Upper instruction field inst[31:12] into J-type immediate
    function automatic logic [XLEN-1:0] imm_of_j(input logic [19:0] hi);
        return {{11{hi[19]}}, hi[19], hi[7:0], hi[8], hi[18:9], 1'b0};
    endfunction

endpackage

// File: rtl/jd_decode.sv
module jd_decode
    import jd_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opcode)
            OPC_OPIMM: begin
                if (funct3 == 3'b000) begin
                    ctrl.rf_we = 1'b1;
                    ctrl.opa   = OPA_RS1;
                    ctrl.opb   = OPB_IMM;
                    ctrl.wbk   = WBK_ALU;
                end
            end
            OPC_OP: begin
                if (funct3 == 3'b000 && (funct7 == F7_BASE || funct7 == F7_ALT)) begin
                    ctrl.rf_we  = 1'b1;
                    ctrl.opa    = OPA_RS1;
                    ctrl.opb    = OPB_RS2;
                    ctrl.alu_fn = (funct7 == F7_ALT) ? ALU_SUB : ALU_ADD;
                    ctrl.wbk    = WBK_ALU;
                end
            end
            OPC_JAL: begin
                ctrl.rf_we    = 1'b1;
                ctrl.opa      = OPA_PC;
                ctrl.opb      = OPB_IMM;
                ctrl.imm_fmt  = IMMF_J;
                ctrl.wbk      = WBK_LINK;
                ctrl.redirect = 1'b1;
            end
            OPC_JALR: begin
                if (funct3 == 3'b000) begin
                    ctrl.rf_we    = 1'b1;
                    ctrl.opa      = OPA_RS1;
                    ctrl.opb      = OPB_IMM;
                    ctrl.wbk      = WBK_LINK;
                    ctrl.redirect = 1'b1;
                    ctrl.clr_lsb  = 1'b1;
                end
            end
            default: ctrl = CTRL_NOP;
        endcase
    end
endmodule

// File: rtl/jd_immgen.sv
module jd_immgen
    import jd_pkg::*;
(
    input  logic [19:0]     inst_hi,
    input  imm_fmt_e        fmt,
    output logic [XLEN-1:0] imm
);
    always_comb begin
        unique case (fmt)
            IMMF_J:  imm = imm_of_j(inst_hi);
            default: imm = imm_of_i(inst_hi);
        endcase
    end
endmodule

// File: rtl/jd_alu.sv
module jd_alu
    import jd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic         cin;

    always_comb begin
        cin   = (fn == ALU_SUB);
        b_eff = cin ? ~b : b;
        y     = a + b_eff + {{(W-1){1'b0}}, cin};
    end
endmodule

// File: rtl/jd_regfile.sv
module jd_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= '0;
                end else if (we && waddr == IW'(g)) begin
                    regs[g] <= wdata;
                end
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/jd_core.sv
module jd_core
    import jd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_wr_en,
    output logic [4:0]      dbg_wr_idx,
    output logic [XLEN-1:0] dbg_wr_data
);
    localparam int NREGS = 32;
    localparam int IW    = $clog2(NREGS);
    localparam logic [XLEN-1:0] STEP    = XLEN'(4);
    localparam logic [XLEN-1:0] MEM_RD0 = '0;

    logic [XLEN-1:0] pc_q, pc_d, pc_inc;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm, rs1_val, rs2_val, op_a, op_b, alu_y, wb_val;
    logic [IW-1:0]   rd, rs1, rs2;
    logic            wr_en;

    assign rd  = imem_data[11:7];
    assign rs1 = imem_data[19:15];
    assign rs2 = imem_data[24:20];

    // Program counter
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_inc = pc_q + STEP;

    jd_decode u_dec (
        .opcode (imem_data[6:0]),
        .funct3 (imem_data[14:12]),
        .funct7 (imem_data[31:25]),
        .ctrl   (ctrl)
    );

    jd_immgen u_imm (
        .inst_hi (imem_data[31:12]),
        .fmt     (ctrl.imm_fmt),
        .imm     (imm)
    );

    jd_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (rd),
        .wdata   (wb_val),
        .raddr_a (rs1),
        .raddr_b (rs2),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val)
    );

    // Operand selection
    always_comb begin
        op_a = (ctrl.opa == OPA_PC)  ? pc_q : rs1_val;
        op_b = (ctrl.opb == OPB_IMM) ? imm  : rs2_val;
    end

    jd_alu #(.W(XLEN)) u_alu (
        .a  (op_a),
        .b  (op_b),
        .fn (ctrl.alu_fn),
        .y  (alu_y)
    );

    // Three-way write-back; memory source tied low (no data memory here)
    always_comb begin
        unique case (ctrl.wbk)
            WBK_LINK: wb_val = pc_inc;
            WBK_MEM:  wb_val = MEM_RD0;
            default:  wb_val = alu_y;
        endcase
    end

    // Next PC
    always_comb begin
        if (ctrl.redirect) pc_d = {alu_y[XLEN-1:1], alu_y[0] & ~ctrl.clr_lsb};
        else               pc_d = pc_inc;
    end

    assign wr_en = ctrl.rf_we && (rd != '0);

    assign imem_addr   = pc_q;
    assign dbg_pc      = pc_q;
    assign dbg_wr_en   = wr_en;
    assign dbg_wr_idx  = rd;
    assign dbg_wr_data = wb_val;
endmodule

// File: rtl/jd_core_chk.sv
module jd_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic [31:0] dbg_pc,
    input logic        dbg_wr_en,
    input logic [4:0]  dbg_wr_idx,
    input logic [31:0] dbg_wr_data
);
    logic        is_jal, is_jalr;
    logic [31:0] j_off;

    assign is_jal  = (imem_data[6:0] == 7'b1101111);
    assign is_jalr = (imem_data[6:0] == 7'b1100111) && (imem_data[14:12] == 3'b000);
    assign j_off   = {{12{imem_data[31]}}, imem_data[19:12], imem_data[20], imem_data[30:21], 1'b0};

    // R1
    fetch_tracks_pc_chk: assert property (@(posedge clk) disable iff (rst)
        imem_addr == dbg_pc);

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_jal && !is_jalr) |=> dbg_pc == $past(dbg_pc) + 32'd4);

    // R3
    jal_target_chk: assert property (@(posedge clk) disable iff (rst)
        is_jal |=> dbg_pc == $past(dbg_pc) + $past(j_off));

    // R3
    jal_link_chk: assert property (@(posedge clk) disable iff (rst)
        (is_jal && imem_data[11:7] != 5'd0) |-> dbg_wr_en && dbg_wr_data == dbg_pc + 32'd4);

    // R4
    jalr_even_chk: assert property (@(posedge clk) disable iff (rst)
        is_jalr |=> dbg_pc[0] == 1'b0);

    // R7
    no_x0_write_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> dbg_wr_idx != 5'd0);

    // R8
    unsupported_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[6:0] == 7'b1110011) |-> !dbg_wr_en);

    // R9
    wr_idx_field_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> dbg_wr_idx == imem_data[11:7]);
endmodule

bind jd_core jd_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_addr   (imem_addr),
    .imem_data   (imem_data),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_idx  (dbg_wr_idx),
    .dbg_wr_data (dbg_wr_data)
);

// File: tb/jd_core_bench.sv
module jd_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dbg_pc, dbg_wr_data;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] rom [64];
    logic [31:0] mregs [32];
    logic [31:0] mpc;
    string       ptag;

    always #4 clk = ~clk;

    assign imem_data = rom[imem_addr[7:2]];

    jd_core u_jd_core (
        .clk (clk), .rst (rst),
        .imem_addr (imem_addr), .imem_data (imem_data),
        .dbg_pc (dbg_pc), .dbg_wr_en (dbg_wr_en),
        .dbg_wr_idx (dbg_wr_idx), .dbg_wr_data (dbg_wr_data)
    );

    function automatic logic [31:0] enc_i(input logic [6:0] opc, input int rd,
                                          input int rs1, input int imm);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'b000, 5'(rd), opc};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rd,
                                          input int rs1, input int rs2);
        return {f7, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_j(input int rd, input int off);
        logic [31:0] v = off;
        return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mregs[i] = '0;
        mpc  = '0;
        ptag = "R1";
    endtask

    // Called away from the clock edge: check outputs, then advance model
    task automatic step_and_check();
        logic [31:0] ins, a, b, ii, jj, wd, np;
        logic [6:0]  opc;
        logic [4:0]  rd;
        logic        we;
        string       tag;
        ins = rom[mpc[7:2]];
        opc = ins[6:0];
        rd  = ins[11:7];
        a   = mregs[ins[19:15]];
        b   = mregs[ins[24:20]];
        ii  = {{20{ins[31]}}, ins[31:20]};
        jj  = {{12{ins[31]}}, ins[19:12], ins[20], ins[30:21], 1'b0};
        we  = 1'b0; wd = '0; np = mpc + 32'd4; tag = "R8";
        if (opc == 7'b0010011 && ins[14:12] == 3'b000) begin
            we = 1'b1; wd = a + ii; tag = "R5";
        end else if (opc == 7'b0110011 && ins[14:12] == 3'b000 && ins[31:25] == 7'b0000000) begin
            we = 1'b1; wd = a + b; tag = "R6";
        end else if (opc == 7'b0110011 && ins[14:12] == 3'b000 && ins[31:25] == 7'b0100000) begin
            we = 1'b1; wd = a - b; tag = "R6";
        end else if (opc == 7'b1101111) begin
            we = 1'b1; wd = mpc + 32'd4; np = mpc + jj; tag = "R3";
        end else if (opc == 7'b1100111 && ins[14:12] == 3'b000) begin
            we = 1'b1; wd = mpc + 32'd4; np = (a + ii) & ~32'd1; tag = "R4";
        end
        // R2: sequential PC is the default np above
        check32((ptag == "R5" || ptag == "R6" || ptag == "R8") ? "R2" : ptag,
                "pc", dbg_pc, mpc);
        check32("R1", "fetch addr", imem_addr, mpc);
        if (we && rd == 5'd0) begin
            // R7: write to register 0 must not show
            check32("R7", "wr_en x0", 32'(dbg_wr_en), 32'd0);
            we = 1'b0;
        end else begin
            check32(tag, "wr_en", 32'(dbg_wr_en), 32'(we));
        end
        if (we) begin
            check32("R9", "wr_idx", 32'(dbg_wr_idx), 32'(rd));
            check32(tag, "wr_data", dbg_wr_data, wd);
            mregs[rd] = wd;
        end
        mpc  = np;
        ptag = tag;
    endtask

    initial begin
        // Add-immediate sweep over every rd, immediates across the signed range
        for (int i = 0; i < 31; i++) rom[i] = enc_i(7'b0010011, i, 0, i * 131 - 2048);
        rom[31] = enc_r(7'b0000001, 9, 1, 2);               // unsupported funct7
        rom[32] = enc_j(1, 8);                              // jal x1, +8
        rom[33] = enc_i(7'b0010011, 2, 0, 1);               // skipped
        rom[34] = enc_i(7'b0010011, 10, 0, 145);            // odd target value
        rom[35] = enc_i(7'b1100111, 11, 10, 0);             // jalr -> 144
        rom[36] = enc_i(7'b0010011, 12, 12, 1);
        rom[37] = enc_r(7'b0000000, 13, 12, 11);
        rom[38] = enc_r(7'b0100000, 14, 13, 1);
        rom[39] = 32'h0000_0073;                            // unsupported opcode
        rom[40] = enc_j(0, 8);                              // jal x0, +8
        rom[41] = enc_i(7'b0010011, 15, 0, 7);              // skipped
        rom[42] = enc_i(7'b0010011, 16, 10, 100);
        rom[43] = enc_i(7'b1100111, 17, 16, -109);          // jalr back to 136
        for (int i = 44; i < 64; i++) rom[i] = enc_i(7'b0010011, 0, 0, 0);
        rom[44] = enc_j(0, -12);                            // unreachable, backward
        rom[45] = enc_r(7'b0000000, 0, 12, 12);             // unreachable

        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check32("R1", "pc after reset", dbg_pc, 32'd0);
        rst = 1'b0;
        for (int n = 0; n < 300; n++) begin
            step_and_check();
            @(negedge clk);
        end

        // Mid-run reset: PC and registers cleared
        rst = 1'b1;
        @(negedge clk);
        check32("R1", "pc mid reset", dbg_pc, 32'd0);
        model_reset();
        rst = 1'b0;
        for (int n = 0; n < 60; n++) begin
            step_and_check();
            @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule